// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the configuration word of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test selector. The word can be written in two ways. The first is a parallel bus, which the block follows while an active-low load strobe is low and which it freezes when that strobe rises. The second is a three-wire serial port made of a serial clock, a data line and a commit strobe. Every pin is asynchronous. Each one passes through a synchronizer into the system clock domain, and the block acts only on synchronized levels and edges.

A serial frame is 14 bits long and is sent first bit first. In sending order it holds the two test bits, one slot that carries nothing, the two output-divide bits, and then the feedback value from its top bit down to its bottom bit. When the commit strobe rises, the shifted frame is copied into the live registers. While the strobe stays high, every serial clock edge also updates the live registers. When the strobe falls, the values are frozen. A test output is driven according to the test bits. A range flag reports a feedback value outside a window that can be set by parameter. The registers start from the parallel pin values present during reset, so pins that are tied on the board give a working configuration without any load event.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `par_load_n` is low, `m_val` and `n_code` follow `par_m` and `par_n`. `t_sel` keeps its value.
- R2: After `par_load_n` rises, `m_val` and `n_code` keep the values held at that edge, even when `par_m` and `par_n` change later.
- R3: In serial mode (`par_load_n` high), each rising `ser_clk` shifts `ser_dat` into a 14-bit frame. A rising `ser_ld` copies the frame into the live registers. The frame order is T[1], T[0], a null slot, N[1], N[0], M[8] down to M[0].
- R4: While `ser_ld` is low, `ser_clk` edges change only the frame. `m_val`, `n_code` and `t_sel` stay unchanged.
- R5: While `ser_ld` is held high, every rising `ser_clk` updates the live registers with the shifted frame.
- R6: In serial mode, `test_out` is selected by `t_sel`: 0 gives low, 1 gives the synchronized `ser_dat`, 2 gives `fb_div_in`, 3 gives `half_rate_in`.
- R7: While the block is in parallel mode, `test_out` is low whatever `t_sel` holds.
- R8: `mr` appears on `div_rst` after synchronization and never changes `m_val`, `n_code` or `t_sel`.
- R9: `m_out_of_range` is high exactly when `m_val` is below `M_MIN` or above `M_MAX`. The defaults are 8 and 28, and both bounds are inclusive.
- R10: While reset is held, `m_val` and `n_code` are loaded from `par_m` and `par_n`, and `t_sel` is cleared to 0. After reset, with `par_load_n` high and no serial activity, these values remain.
- R11: The bit in the null slot has no effect on any live register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_load_n | input | 1 | Parallel load strobe, active low |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial commit strobe |
| mr | input | 1 | Master divider reset request |
| fb_div_in | input | 1 | Feedback divider output, routed to the test pin |
| half_rate_in | input | 1 | Half-rate synthesizer output, routed to the test pin |
| m_val | output | 9 | Live feedback divide value |
| n_code | output | 2 | Live output divide code |
| t_sel | output | 2 | Live test selector |
| test_out | output | 1 | Test output |
| m_out_of_range | output | 1 | Feedback value outside the valid window |
| div_rst | output | 1 | Synchronized divider reset |

## Verification
A pin change takes two system edges to pass the synchronizer. The edge detector and the state machine act on the third edge. The live registers therefore show a parallel-bus value, a commit or a flow-through update on the third or fourth edge after the pin moves. `div_rst` and the echoed data on `test_out` follow on the second edge. The bench holds each serial data bit for four cycles on each side of its clock edge, waits at least six cycles after every strobe movement, and samples on the falling clock edge. No check therefore falls inside a transition window. The range flag and the test selection are combinational from the live registers and are checked in the same sample.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    // The field widths are fixed by the serial frame format
    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 2;
    localparam int FRAME_W = T_W + 1 + N_W + M_W;

    // Bit positions inside the shift register once a whole frame has gone in
    localparam int POS_M   = 0;
    localparam int POS_N   = POS_M + M_W;
    localparam int POS_NUL = POS_N + N_W;
    localparam int POS_T   = POS_NUL + 1;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_TRACK,
        ST_SHIFT,
        ST_LOAD,
        ST_FLOW
    } ld_state_e;

endpackage

// File: rtl/cfg_sync_chain.sv
module cfg_sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter
    import cfg_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shift_en,
    input  logic      din,
    output cfg_word_t cur_word,
    output cfg_word_t nxt_word
);

    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[FRAME_W-2:0], din};
    end

    // Fields of the frame as it stands now
    assign cur_word.t = sr[POS_T +: T_W];
    assign cur_word.n = sr[POS_N +: N_W];
    assign cur_word.m = sr[POS_M +: M_W];

    // Fields as they will stand once din has been shifted in; the null slot is skipped
    assign nxt_word.t = sr[POS_T-1 +: T_W];
    assign nxt_word.n = sr[POS_N-1 +: N_W];
    assign nxt_word.m = {sr[M_W-2:0], din};

endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
    import cfg_loader_pkg::*;
#(
    parameter int BOOT_CYC = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] boot_m,
    input  logic [N_W-1:0] boot_n,
    input  logic [M_W-1:0] pin_m,
    input  logic [N_W-1:0] pin_n,
    input  logic           plo_n_s,
    input  logic           ld_s,
    input  logic           sclk_rise,
    input  cfg_word_t      sr_word,
    input  cfg_word_t      sr_next,
    output ld_state_e      state,
    output cfg_word_t      cfg,
    output logic           shift_en,
    output logic           ser_mode
);

    localparam int CNT_W = $clog2(BOOT_CYC + 1);
    localparam logic [CNT_W-1:0] BOOT_LAST = CNT_W'(BOOT_CYC);

    ld_state_e        nxt;
    logic [CNT_W-1:0] boot_cnt;
    logic             boot_done;

    assign boot_done = (boot_cnt == BOOT_LAST);

    // State register and the counter that lets the synchronizers fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_BOOT;
            boot_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_BOOT && !boot_done) boot_cnt <= boot_cnt + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT: begin
                if (boot_done) begin
                    if (!plo_n_s)  nxt = ST_TRACK;
                    else if (ld_s) nxt = ST_FLOW;
                    else           nxt = ST_SHIFT;
                end
            end
            ST_TRACK: begin
                if (plo_n_s) nxt = ld_s ? ST_FLOW : ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!plo_n_s)  nxt = ST_TRACK;
                else if (ld_s) nxt = ST_LOAD;
            end
            ST_LOAD: begin
                if (!plo_n_s)  nxt = ST_TRACK;
                else if (ld_s) nxt = ST_FLOW;
                else           nxt = ST_SHIFT;
            end
            ST_FLOW: begin
                if (!plo_n_s)  nxt = ST_TRACK;
                else if (!ld_s) nxt = ST_SHIFT;
            end
            default: nxt = ST_BOOT;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        ser_mode = (state == ST_SHIFT) || (state == ST_LOAD) || (state == ST_FLOW);
        shift_en = ser_mode && sclk_rise;
    end

    // Live configuration register; during reset it takes the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.t <= '0;
            cfg.n <= boot_n;
            cfg.m <= boot_m;
        end else begin
            case (state)
                ST_TRACK: begin
                    cfg.m <= pin_m;
                    cfg.n <= pin_n;
                end
                ST_LOAD: cfg <= sr_word;
                ST_FLOW: if (sclk_rise) cfg <= sr_next;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
    import cfg_loader_pkg::*;
(
    input  logic           ser_mode,
    input  logic [T_W-1:0] t,
    input  logic           echo,
    input  logic           fb_div,
    input  logic           half_rate,
    output logic           y
);

    always_comb begin
        y = 1'b0;
        if (ser_mode) begin
            unique case (t)
                2'd0: y = 1'b0;
                2'd1: y = echo;
                2'd2: y = fb_div;
                2'd3: y = half_rate;
                default: y = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int M_MIN       = 8,
    parameter int M_MAX       = 28,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_ld,
    input  logic           mr,
    input  logic           fb_div_in,
    input  logic           half_rate_in,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_code,
    output logic [T_W-1:0] t_sel,
    output logic           test_out,
    output logic           m_out_of_range,
    output logic           div_rst
);

    localparam int PIN_W  = M_W + N_W;
    localparam int CTRL_W = 5;
    localparam logic [M_W-1:0] M_LO = M_W'(M_MIN);
    localparam logic [M_W-1:0] M_HI = M_W'(M_MAX);

    logic [PIN_W-1:0]  pins_s;
    logic [CTRL_W-1:0] ctrl_s;
    logic              plo_n_s, sclk_s, sdat_s, sld_s;
    logic              sclk_prev, sclk_rise;
    logic              shift_en, ser_mode;
    cfg_word_t         sr_cur, sr_nxt, cfg_q;
    ld_state_e         st;

    cfg_sync_chain #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({par_n, par_m}),
        .q       (pins_s)
    );

    cfg_sync_chain #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({mr, ser_ld, ser_dat, ser_clk, par_load_n}),
        .q       (ctrl_s)
    );

    assign plo_n_s = ctrl_s[0];
    assign sclk_s  = ctrl_s[1];
    assign sdat_s  = ctrl_s[2];
    assign sld_s   = ctrl_s[3];
    assign div_rst = ctrl_s[4];

    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end
    assign sclk_rise = sclk_s && !sclk_prev;

    cfg_frame_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (sdat_s),
        .cur_word (sr_cur),
        .nxt_word (sr_nxt)
    );

    cfg_load_fsm #(.BOOT_CYC(SYNC_STAGES + 1)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_m    (par_m),
        .boot_n    (par_n),
        .pin_m     (pins_s[M_W-1:0]),
        .pin_n     (pins_s[PIN_W-1:M_W]),
        .plo_n_s   (plo_n_s),
        .ld_s      (sld_s),
        .sclk_rise (sclk_rise),
        .sr_word   (sr_cur),
        .sr_next   (sr_nxt),
        .state     (st),
        .cfg       (cfg_q),
        .shift_en  (shift_en),
        .ser_mode  (ser_mode)
    );

    cfg_test_mux u_tmux (
        .ser_mode  (ser_mode),
        .t         (cfg_q.t),
        .echo      (sdat_s),
        .fb_div    (fb_div_in),
        .half_rate (half_rate_in),
        .y         (test_out)
    );

    assign m_val          = cfg_q.m;
    assign n_code         = cfg_q.n;
    assign t_sel          = cfg_q.t;
    assign m_out_of_range = (cfg_q.m < M_LO) || (cfg_q.m > M_HI);

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
    import cfg_loader_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input ld_state_e state,
    input cfg_word_t cfg,
    input cfg_word_t sr_word,
    input logic      clk_rise,
    input logic      dat_s,
    input logic      test_out
);

    // R7: no test activity while the parallel bus is being followed
    assert_par_test_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK) |-> !test_out);

    // R4: with the commit strobe low the live word stays put
    assert_hold_in_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |=> $stable(cfg));

    // R3: a commit copies the assembled frame
    assert_load_copies_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (cfg == $past(sr_word)));

    // R5: flow-through puts the newest serial bit at the bottom of M
    assert_flow_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOW && clk_rise) |=> (cfg.m[0] == $past(dat_s)));

    // R6: selector zero keeps the test pin low in serial mode
    assert_test_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SHIFT || state == ST_LOAD || state == ST_FLOW) && cfg.t == 2'd0)
        |-> !test_out);

endmodule

bind synth_cfg_loader cfg_loader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (st),
    .cfg      (cfg_q),
    .sr_word  (sr_cur),
    .clk_rise (sclk_rise),
    .dat_s    (sdat_s),
    .test_out (test_out)
);

// File: tb/test_synth_cfg_loader.sv
`timescale 1ns/1ps
module test_synth_cfg_loader;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load_n = 1'b1;
    logic [8:0] par_m = 9'd0;
    logic [1:0] par_n = 2'd0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, mr = 1'b0;
    logic       fb_div_in = 1'b0, half_rate_in = 1'b0;
    logic [8:0] m_val;
    logic [1:0] n_code, t_sel;
    logic       test_out, m_out_of_range, div_rst;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    // Vector layout: {oor, null bit, t[1:0], n[1:0], m[8:0]}
    localparam logic [14:0] VEC [6] = '{
        {1'b0, 1'b0, 2'd0, 2'd1, 9'd8},
        {1'b0, 1'b1, 2'd1, 2'd2, 9'd28},
        {1'b1, 1'b0, 2'd2, 2'd3, 9'd7},
        {1'b1, 1'b1, 2'd3, 2'd0, 9'd29},
        {1'b1, 1'b0, 2'd0, 2'd2, 9'd511},
        {1'b0, 1'b0, 2'd2, 2'd1, 9'd20}
    };

    always #2.5 clk = ~clk;

    synth_cfg_loader i_synth_cfg_loader (
        .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
        .par_n(par_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
        .mr(mr), .fb_div_in(fb_div_in), .half_rate_in(half_rate_in),
        .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .test_out(test_out),
        .m_out_of_range(m_out_of_range), .div_rst(div_rst)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        cyc(4);
        ser_clk = 1'b1;
        cyc(4);
        ser_clk = 1'b0;
        cyc(2);
    endtask

    task automatic send_frame(input logic [1:0] t, input logic nul,
                              input logic [1:0] n, input logic [8:0] m);
        logic [13:0] f;
        f = {t, nul, n, m};
        for (int i = 13; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic commit();
        ser_ld = 1'b1;
        cyc(6);
        ser_ld = 1'b0;
        cyc(6);
    endtask

    task automatic chk_cfg(input string req, input logic [1:0] t,
                           input logic [1:0] n, input logic [8:0] m);
        chk({req, " m"}, 32'(m_val), 32'(m));
        chk({req, " n"}, 32'(n_code), 32'(n));
        chk({req, " t"}, 32'(t_sel), 32'(t));
    endtask

    initial begin
        // R10: tied pins seen during reset give the starting word
        par_m = 9'd25;
        par_n = 2'd2;
        cyc(5);
        rst_n = 1'b1;
        cyc(8);
        chk_cfg("R10 reset", 2'd0, 2'd2, 9'd25);
        chk("R10 oor", 32'(m_out_of_range), 0);
        chk("R6 test low t0", 32'(test_out), 0);
        chk("R8 div_rst idle", 32'(div_rst), 0);

        // R3 R9 R11 R6: serial frames from the table
        for (int k = 0; k < 6; k++) begin
            logic [14:0] v;
            v = VEC[k];
            send_frame(v[12:11], v[13], v[10:9], v[8:0]);
            commit();
            chk_cfg("R3 R11 frame", v[12:11], v[10:9], v[8:0]);
            chk("R9 oor", 32'(m_out_of_range), 32'(v[14]));
            case (v[12:11])
                2'd0: chk("R6 sel0", 32'(test_out), 0);
                2'd1: begin
                    ser_dat = 1'b1; cyc(4); chk("R6 echo1", 32'(test_out), 1);
                    ser_dat = 1'b0; cyc(4); chk("R6 echo0", 32'(test_out), 0);
                end
                2'd2: begin
                    fb_div_in = 1'b1; cyc(1); chk("R6 fb1", 32'(test_out), 1);
                    fb_div_in = 1'b0; cyc(1); chk("R6 fb0", 32'(test_out), 0);
                end
                default: begin
                    half_rate_in = 1'b1; cyc(1); chk("R6 half1", 32'(test_out), 1);
                    half_rate_in = 1'b0; cyc(1); chk("R6 half0", 32'(test_out), 0);
                end
            endcase
        end

        // R4: serial clocks without a commit leave the live word alone
        send_frame(2'd3, 1'b0, 2'd0, 9'd9);
        chk_cfg("R4 no commit", 2'd2, 2'd1, 9'd20);

        // R5: strobe held high, each serial clock updates the live word
        ser_ld = 1'b1;
        cyc(6);
        chk_cfg("R3 commit", 2'd3, 2'd0, 9'd9);
        send_bit(1'b1);
        chk_cfg("R5 flow one bit", 2'd2, 2'd0, 9'd19);
        send_frame(2'd1, 1'b0, 2'd2, 9'd10);
        chk_cfg("R5 flow frame", 2'd1, 2'd2, 9'd10);
        ser_ld = 1'b0;
        cyc(6);
        send_bit(1'b1);
        chk_cfg("R4 frozen after fall", 2'd1, 2'd2, 9'd10);

        // R8: master reset request does not touch the word
        mr = 1'b1;
        cyc(4);
        chk("R8 div_rst high", 32'(div_rst), 1);
        chk_cfg("R8 cfg kept", 2'd1, 2'd2, 9'd10);
        mr = 1'b0;
        cyc(4);
        chk("R8 div_rst low", 32'(div_rst), 0);

        // R1 R7: follow the parallel bus; test pin forced low
        par_m = 9'd12;
        par_n = 2'd3;
        par_load_n = 1'b0;
        ser_dat = 1'b1;
        cyc(6);
        chk_cfg("R1 track", 2'd1, 2'd3, 9'd12);
        chk("R7 test low", 32'(test_out), 0);
        par_m = 9'd30; cyc(6);
        chk("R1 track m", 32'(m_val), 30);
        chk("R9 above max", 32'(m_out_of_range), 1);
        par_m = 9'd8; cyc(6);
        chk("R9 min edge", 32'(m_out_of_range), 0);
        par_m = 9'd28; cyc(6);
        chk("R9 max edge", 32'(m_out_of_range), 0);

        // R2: rising strobe latches the bus
        par_load_n = 1'b1;
        cyc(6);
        par_m = 9'd9;
        par_n = 2'd0;
        cyc(6);
        chk_cfg("R2 latched", 2'd1, 2'd3, 9'd28);
        chk("R6 echo after parallel", 32'(test_out), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule